// File: doc/BRIEF.md
# Fetch-and-Add Reply Splitter

A combining switch merges two fetch-and-add requests that target the same word into one request before sending it toward memory. This block keeps the information needed to undo each merge on the return path. The combining logic writes one record per merge: the tag of the request that went on to memory, the tag of the request that was absorbed into it, and the addend of the request that was ordered first. Fetch-and-add returns the old memory value and stores the old value plus the addend. A merged reply therefore has to be split into two replies whose values match some serial order of the two original requests.

Each reply from memory is looked up by tag across all stored records. On a hit, the reply leaves unchanged for the forwarded requester. On the next cycle a second reply leaves for the absorbed requester, carrying the returned value plus the stored addend, and the record is freed. On a miss, the reply passes through after one register stage. When every record is in use, a full flag tells the memory-bound inputs to stop accepting traffic.

Top module: `fa_decombine_buf`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid_o` and `full` are low and `rsp_ready_o` is high.
- R2: A reply accepted on `rsp_valid_i && rsp_ready_o` whose tag matches no stored record appears on the output one cycle later, with tag and value unchanged, as a single reply.
- R3: A reply accepted with a tag that matches a stored record's forwarded tag appears one cycle later, with its own tag and unchanged value. This is the reply for the first-ordered requester.
- R4: On the cycle after R3's reply, a second reply appears with the record's absorbed tag and the value `returned + addend` modulo 2^DATA_W. For example, addends 4 then 8 merged at value 0 yield replies 0 and 4.
- R5: `rsp_ready_o` is low for exactly the one cycle in which the first reply of a split is on the output. A reply offered during that cycle is not accepted and produces no output.
- R6: A record is freed when its reply is accepted. A later reply with the same tag is a miss.
- R7: `full` is high when all DEPTH records are occupied. A write presented while `full` is high is dropped, so a later reply with that tag misses.
- R8: A write and an accepted reply in the same cycle both take effect. The reply's lookup does not see the record written in that cycle.
- R9: When a hit frees a record in a full buffer, `full` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store a merge record |
| wr_fwd_tag | input | TAG_W | Tag of the request sent on to memory |
| wr_abs_tag | input | TAG_W | Tag of the absorbed request |
| wr_addend | input | DATA_W | Addend of the first-ordered request |
| full | output | 1 | All records occupied |
| rsp_valid_i | input | 1 | Reply from memory valid |
| rsp_tag_i | input | TAG_W | Reply tag |
| rsp_data_i | input | DATA_W | Returned old value |
| rsp_ready_o | output | 1 | Reply input accepted this cycle |
| rsp_valid_o | output | 1 | Reply toward processors valid |
| rsp_tag_o | output | TAG_W | Outgoing reply tag |
| rsp_data_o | output | DATA_W | Outgoing reply value |

## Verification
The bench holds a reply on the input through a split and expects exactly one acceptance. A design that ignored the stall would either lose the waiting reply or emit three replies. The bench reuses a tag after its record was freed and expects a plain pass-through, which catches a design that forgets to clear the record and splits twice. It fills all sixteen records, offers a write while full, drains one record and then writes and looks up in the same cycle. This exposes a full flag that is off by one, a dropped write that still occupies a slot, and a lookup that wrongly matches the record written in its own cycle. Sums that wrap past the top of the data width confirm that the second value is taken modulo 2^DATA_W.

// File: rtl/fa_decombine_buf.sv
module fa_decombine_buf #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_fwd_tag,
  input  logic [TAG_W-1:0]  wr_abs_tag,
  input  logic [DATA_W-1:0] wr_addend,
  output logic              full,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              rsp_ready_o,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  occ;
  logic [TAG_W-1:0]  fwd_q [DEPTH];
  logic [TAG_W-1:0]  abs_q [DEPTH];
  logic [DATA_W-1:0] add_q [DEPTH];

  logic              pend_v;
  logic [TAG_W-1:0]  pend_tag;
  logic [DATA_W-1:0] pend_data;

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  free_idx;
  logic              accept, do_wr;

  assign full        = &occ;
  assign rsp_ready_o = ~pend_v;
  assign accept      = rsp_valid_i & rsp_ready_o;
  assign do_wr       = wr_en & ~full;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (occ[i] && fwd_q[i] == rsp_tag_i) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_wr && free_idx == IDX_W'(i))
          occ[i] <= 1'b1;
        else if (accept && hit && hit_idx == IDX_W'(i))
          occ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      fwd_q[free_idx] <= wr_fwd_tag;
      abs_q[free_idx] <= wr_abs_tag;
      add_q[free_idx] <= wr_addend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v      <= 1'b0;
      pend_tag    <= '0;
      pend_data   <= '0;
      rsp_valid_o <= 1'b0;
      rsp_tag_o   <= '0;
      rsp_data_o  <= '0;
    end else if (pend_v) begin
      pend_v      <= 1'b0;
      rsp_valid_o <= 1'b1;
      rsp_tag_o   <= pend_tag;
      rsp_data_o  <= pend_data;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_tag_o  <= rsp_tag_i;
        rsp_data_o <= rsp_data_i;
      end
      if (accept && hit) begin
        pend_v    <= 1'b1;
        pend_tag  <= abs_q[hit_idx];
        pend_data <= rsp_data_i + add_q[hit_idx];
      end
    end
  end
endmodule

// File: rtl/fa_decombine_buf_chk.sv
module fa_decombine_buf_chk #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              full,
  input logic              rsp_valid_i,
  input logic [TAG_W-1:0]  rsp_tag_i,
  input logic [DATA_W-1:0] rsp_data_i,
  input logic              rsp_ready_o,
  input logic              rsp_valid_o,
  input logic [TAG_W-1:0]  rsp_tag_o,
  input logic [DATA_W-1:0] rsp_data_o
);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($past(rsp_valid_i && rsp_ready_o) || $past(!rsp_ready_o)));

  assert_echo_accepted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_i && rsp_ready_o) |=>
      (rsp_valid_o && rsp_tag_o == $past(rsp_tag_i) && rsp_data_o == $past(rsp_data_i)));

  assert_first_during_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready_o |-> rsp_valid_o);

  assert_second_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready_o |=> rsp_valid_o);

  assert_stall_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready_o |=> rsp_ready_o);

  assert_full_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_en));

  assert_full_drop_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(rsp_valid_i && rsp_ready_o));
endmodule

bind fa_decombine_buf fa_decombine_buf_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .full(full),
  .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i), .rsp_data_i(rsp_data_i),
  .rsp_ready_o(rsp_ready_o), .rsp_valid_o(rsp_valid_o),
  .rsp_tag_o(rsp_tag_o), .rsp_data_o(rsp_data_o)
);

// File: tb/fa_decombine_buf_tb.sv
module fa_decombine_buf_tb;
  localparam int DEPTH  = 16;
  localparam int TAG_W  = 8;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [TAG_W-1:0]  wr_fwd_tag = '0, wr_abs_tag = '0, rsp_tag_i = '0;
  logic [DATA_W-1:0] wr_addend = '0, rsp_data_i = '0;
  logic rsp_valid_i = 1'b0;
  logic full, rsp_ready_o, rsp_valid_o;
  logic [TAG_W-1:0]  rsp_tag_o;
  logic [DATA_W-1:0] rsp_data_o;

  always #2 clk = ~clk;

  fa_decombine_buf #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fwd_tag(wr_fwd_tag),
    .wr_abs_tag(wr_abs_tag), .wr_addend(wr_addend), .full(full),
    .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i), .rsp_data_i(rsp_data_i),
    .rsp_ready_o(rsp_ready_o), .rsp_valid_o(rsp_valid_o),
    .rsp_tag_o(rsp_tag_o), .rsp_data_o(rsp_data_o));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  bit                m_vld [DEPTH];
  logic [TAG_W-1:0]  m_fwd [DEPTH];
  logic [TAG_W-1:0]  m_abs [DEPTH];
  logic [DATA_W-1:0] m_add [DEPTH];
  bit                m_freed [2**TAG_W];
  bit                m_pend_v, m_out_v, m_full_prev;
  logic [TAG_W-1:0]  m_pend_tag, m_out_tag;
  logic [DATA_W-1:0] m_pend_data, m_out_data;
  string             m_lbl = "R2";

  function automatic bit m_full();
    for (int i = 0; i < DEPTH; i++) if (!m_vld[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_has_fwd(logic [TAG_W-1:0] t);
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_fwd[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
      m_pend_v = 1'b0; m_out_v = 1'b0; m_full_prev = 1'b0;
    end else begin
      bit acc, fnow;
      int wi, hi;
      fnow = m_full();
      m_full_prev = fnow;
      acc = rsp_valid_i && !m_pend_v;
      wi = -1;
      if (wr_en && !fnow)
        for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) wi = i;
      if (m_pend_v) begin
        m_out_v = 1'b1; m_out_tag = m_pend_tag; m_out_data = m_pend_data;
        m_pend_v = 1'b0; m_lbl = "R4";
      end else if (acc) begin
        m_out_v = 1'b1; m_out_tag = rsp_tag_i; m_out_data = rsp_data_i;
        hi = -1;
        for (int i = DEPTH - 1; i >= 0; i--)
          if (m_vld[i] && m_fwd[i] == rsp_tag_i) hi = i;
        if (hi >= 0) begin
          m_pend_v = 1'b1; m_pend_tag = m_abs[hi];
          m_pend_data = rsp_data_i + m_add[hi];
          m_vld[hi] = 1'b0; m_freed[rsp_tag_i] = 1'b1;
          m_lbl = (wi >= 0) ? "R8" : "R3";
        end else begin
          m_lbl = m_freed[rsp_tag_i] ? "R6" : ((wi >= 0) ? "R8" : "R2");
        end
      end else begin
        m_out_v = 1'b0;
      end
      if (wi >= 0) begin
        m_vld[wi] = 1'b1; m_fwd[wi] = wr_fwd_tag;
        m_abs[wi] = wr_abs_tag; m_add[wi] = wr_addend;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit f;
      f = m_full();
      chk(rsp_valid_o === m_out_v, m_lbl, "valid", rsp_valid_o, m_out_v);
      if (m_out_v) begin
        chk(rsp_tag_o === m_out_tag, m_lbl, "tag", rsp_tag_o, m_out_tag);
        chk(rsp_data_o === m_out_data, m_lbl, "data", rsp_data_o, m_out_data);
      end
      chk(rsp_ready_o === !m_pend_v, "R5", "ready", rsp_ready_o, !m_pend_v);
      chk(full === f, (m_full_prev && !f) ? "R9" : "R7", "full", full, f);
    end
  end

  task automatic wr(logic [TAG_W-1:0] ft, logic [TAG_W-1:0] at, logic [DATA_W-1:0] ad);
    @(negedge clk);
    wr_en = 1'b1; wr_fwd_tag = ft; wr_abs_tag = at; wr_addend = ad;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rsp(logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    @(negedge clk);
    rsp_valid_i = 1'b1; rsp_tag_i = t; rsp_data_i = d;
    @(negedge clk);
    rsp_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rsp_valid_o === 1'b0, "R1", "valid in reset", rsp_valid_o, 0);
    chk(full === 1'b0, "R1", "full in reset", full, 0);
    chk(rsp_ready_o === 1'b1, "R1", "ready in reset", rsp_ready_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid_o === 1'b0 && full === 1'b0 && rsp_ready_o === 1'b1, "R1",
        "post reset", {rsp_valid_o, full, rsp_ready_o}, 3'b001);

    rsp(8'd5, 16'h1234);
    rsp(8'd6, 16'h0042);
    idle(2);

    wr(8'd10, 8'd11, 16'd4);
    rsp(8'd10, 16'd0);
    idle(3);

    wr(8'd20, 8'd21, 16'd3);
    @(negedge clk);
    rsp_valid_i = 1'b1; rsp_tag_i = 8'd20; rsp_data_i = 16'hFFFF;
    @(negedge clk);
    rsp_tag_i = 8'd30; rsp_data_i = 16'h0777;
    @(negedge clk);
    rsp_tag_i = 8'd31; rsp_data_i = 16'h0888;
    @(negedge clk);
    rsp_valid_i = 1'b0;
    idle(3);

    rsp(8'd10, 16'h0055);
    idle(2);

    for (int k = 0; k < DEPTH; k++) wr(8'(100 + k), 8'(200 + k), 16'(k + 1));
    idle(1);
    chk(full === 1'b1, "R7", "full after fill", full, 1);
    wr(8'd120, 8'd121, 16'd9);
    rsp(8'd120, 16'h0AAA);
    chk(rsp_valid_o === 1'b1 && rsp_tag_o === 8'd120, "R7", "dropped write reply",
        rsp_tag_o, 8'd120);
    @(negedge clk);
    chk(rsp_valid_o === 1'b0, "R7", "no split on dropped write", rsp_valid_o, 0);

    rsp(8'd103, 16'd50);
    chk(full === 1'b0, "R9", "full cleared", full, 0);
    idle(2);

    @(negedge clk);
    wr_en = 1'b1; wr_fwd_tag = 8'd130; wr_abs_tag = 8'd131; wr_addend = 16'd7;
    rsp_valid_i = 1'b1; rsp_tag_i = 8'd130; rsp_data_i = 16'h0100;
    @(negedge clk);
    wr_en = 1'b0; rsp_valid_i = 1'b0;
    chk(rsp_valid_o === 1'b1 && rsp_ready_o === 1'b1, "R8", "same-cycle miss",
        {rsp_valid_o, rsp_ready_o}, 2'b11);
    rsp(8'd130, 16'h0200);
    idle(2);

    for (int k = 0; k < DEPTH; k++) begin
      rsp(8'(100 + k), 16'(1000 * k));
      idle(1);
    end

    for (int c = 0; c < 3000; c++) begin
      logic [TAG_W-1:0] t;
      @(negedge clk);
      t = 8'($urandom_range(0, 63));
      wr_en = ($urandom_range(0, 2) == 0) && !m_has_fwd(t);
      wr_fwd_tag = t;
      wr_abs_tag = 8'($urandom_range(64, 255));
      wr_addend = 16'($urandom);
      rsp_valid_i = ($urandom_range(0, 1) == 0);
      rsp_tag_i = 8'($urandom_range(0, 63));
      rsp_data_i = 16'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0; rsp_valid_i = 1'b0;
    idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule